// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between six active-high PWM gate requests (a high-side and a low-side request for each of the phases U, V and W) and the six gate-enable outputs that feed the drivers. It lets a request through only when no protective condition blocks that switch. It also forces switches off when a supply drops too low or when the low-side current comparator reports a short circuit. Supply and short-circuit conditions arrive as digital flags. Analog sensing, thresholds and the driving of the gates are done elsewhere.

Supply undervoltage is modelled with hysteresis as two flags per supply. A detect flag engages a lockout at once. A separate clear flag, which rises at a higher supply level, releases it. The low-side supply lockout and a filtered short-circuit trip both force all three low-side gates off and start an active-low fault pulse of at least a programmable number of cycles. A high-side supply lockout turns off only the high-side gate of its own phase and never touches the fault pin. After any protective shutdown, a gate comes back only when its request falls and then rises again.

The fault timer is a two-state machine. `FT_IDLE` holds the fault pin high. The transition `IDLE->HOLD` is taken on a trigger. In `FT_HOLD` the pin is low while a counter runs down. When the count expires, the transition `HOLD->HOLD` (reload) is taken if the trigger is still present, and the transition `HOLD->IDLE` is taken if it is not.

Top module: `gate_guard_top`

## Requirements
- R1: While reset is asserted and after its release, all six gates are off and `fault_n` is 1. A request that is already high at reset release does not enable its gate until it has gone low and then high again.
- R2: An enabled gate follows its request in the same cycle. A gate is never on while its request is 0.
- R3: `ls_uv_det`=1 forces all three low-side gates off in the same cycle. The lockout persists after `ls_uv_det` falls and ends only at a clock edge where `ls_uv_clr`=1 and `ls_uv_det`=0. High-side gates are unaffected.
- R4: A sampled `ls_uv_det`=1 with the fault timer idle drives `fault_n` to 0 from the following cycle.
- R5: `hs_uv_det[i]`=1 (bit 0 = U, 1 = V, 2 = W) forces only `gate_hi[i]` off. It latches until an edge with `hs_uv_clr[i]`=1 and `hs_uv_det[i]`=0, and never changes `fault_n` or the other gates.
- R6: `sc_flag` high for SC_FILT consecutive sampled edges trips the short-circuit protection. All low-side gates are off from the cycle after the SC_FILT-th edge, for as long as the flag stays high. Shorter bursts have no effect.
- R7: A short-circuit trip leaves the high-side gates unaffected. It starts a fault pulse one cycle after the trip.
- R8: A single trigger holds `fault_n` at 0 for exactly FO_CYC cycles. A trigger during the pulse neither shortens nor extends it. A trigger still present when the count expires restarts the pulse with no high gap.
- R9: While `fault_n` is 0, no low-side gate is on, including for requests that rise during the pulse.
- R10: After any blocking condition ends, a gate whose request is still high stays off. It turns on only after the request goes 0 and then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lo | input | 3 | Low-side gate requests, bit 0 = U, 1 = V, 2 = W |
| req_hi | input | 3 | High-side gate requests, same bit order |
| ls_uv_det | input | 1 | Low-side supply below detect level |
| ls_uv_clr | input | 1 | Low-side supply above release level |
| hs_uv_det | input | 3 | Per-phase high-side supply below detect level |
| hs_uv_clr | input | 3 | Per-phase high-side supply above release level |
| sc_flag | input | 1 | Synchronized short-circuit comparator output |
| gate_lo | output | 3 | Low-side gate enables |
| gate_hi | output | 3 | High-side gate enables |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the sampling edge. They also assume that the detect and clear flags of a supply reflect a physical level, so that a clear does not coincide with a detect in the intended use, even though the design gives detect priority if both occur together. The stimulus changes every input only at the falling clock edge. It holds the clear flags low whenever the matching detect flag is high. It drives `sc_flag` with bursts both shorter and longer than the filter length, so that the sampled values always meet these assumptions.

// File: rtl/gg_pkg.sv
package gg_pkg;
    localparam int N_PHASE = 3;

    typedef enum logic [0:0] {
        FT_IDLE = 1'b0,
        FT_HOLD = 1'b1
    } ft_state_e;
endpackage

// File: rtl/gg_uv_latch.sv
module gg_uv_latch #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] det,
    input  logic [W-1:0] clr,
    output logic [W-1:0] lock
);
    // Detect has priority; the release level only clears a held lockout.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock <= '0;
        end else begin
            lock <= det | (lock & ~clr);
        end
    end
endmodule

// File: rtl/gg_sc_filter.sv
module gg_sc_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_raw,
    output logic trip
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            trip  <= 1'b0;
        end else if (!sc_raw) begin
            run_q <= '0;
            trip  <= 1'b0;
        end else if (run_q == LAST) begin
            trip  <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/gg_fault_timer.sv
module gg_fault_timer
    import gg_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic fault_n,
    output logic hold
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(WIDTH - 1);

    ft_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FT_IDLE: begin
                if (trig) begin
                    state_d = FT_HOLD;
                    cnt_d   = RELOAD;
                end
            end
            FT_HOLD: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (trig) begin
                    cnt_d = RELOAD;
                end else begin
                    state_d = FT_IDLE;
                end
            end
            default: state_d = FT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            FT_IDLE: begin
                fault_n = 1'b1;
                hold    = 1'b0;
            end
            FT_HOLD: begin
                fault_n = 1'b0;
                hold    = 1'b1;
            end
            default: begin
                fault_n = 1'b1;
                hold    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gg_rearm.sv
module gg_rearm #(
    parameter int CH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] req,
    input  logic [CH-1:0] block,
    output logic [CH-1:0] gate
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic prev_q;
        logic armed_q;
        logic rise;

        assign rise    = req[c] & ~prev_q;
        assign gate[c] = req[c] & ~block[c] & (armed_q | rise);

        // prev resets high so a request held through reset needs a new edge.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                prev_q  <= req[c];
                armed_q <= req[c] & ~block[c] & (armed_q | rise);
            end
        end
    end
endmodule

// File: rtl/gate_guard_top.sv
module gate_guard_top
    import gg_pkg::*;
#(
    parameter int FO_CYC  = 16,
    parameter int SC_FILT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   req_lo,
    input  logic [2:0]   req_hi,
    input  logic         ls_uv_det,
    input  logic         ls_uv_clr,
    input  logic [2:0]   hs_uv_det,
    input  logic [2:0]   hs_uv_clr,
    input  logic         sc_flag,
    output logic [2:0]   gate_lo,
    output logic [2:0]   gate_hi,
    output logic         fault_n
);
    localparam int NCH = 2 * N_PHASE;

    logic                ls_lock;
    logic [N_PHASE-1:0]  hs_lock;
    logic                sc_trip;
    logic                fo_hold;
    logic                lo_block;
    logic [N_PHASE-1:0]  hi_block;
    logic [NCH-1:0]      ch_req, ch_block, ch_gate;

    gg_uv_latch #(.W(1)) u_ls_uv (
        .clk(clk), .rst_n(rst_n), .det(ls_uv_det), .clr(ls_uv_clr), .lock(ls_lock)
    );

    gg_uv_latch #(.W(N_PHASE)) u_hs_uv (
        .clk(clk), .rst_n(rst_n), .det(hs_uv_det), .clr(hs_uv_clr), .lock(hs_lock)
    );

    gg_sc_filter #(.FILT(SC_FILT)) u_sc (
        .clk(clk), .rst_n(rst_n), .sc_raw(sc_flag), .trip(sc_trip)
    );

    gg_fault_timer #(.WIDTH(FO_CYC)) u_fo (
        .clk(clk), .rst_n(rst_n), .trig(ls_uv_det | sc_trip),
        .fault_n(fault_n), .hold(fo_hold)
    );

    assign lo_block = ls_uv_det | ls_lock | sc_trip | fo_hold;
    assign hi_block = hs_uv_det | hs_lock;

    assign ch_req   = {req_hi, req_lo};
    assign ch_block = {hi_block, {N_PHASE{lo_block}}};

    gg_rearm #(.CH(NCH)) u_rearm (
        .clk(clk), .rst_n(rst_n), .req(ch_req), .block(ch_block), .gate(ch_gate)
    );

    assign gate_lo = ch_gate[N_PHASE-1:0];
    assign gate_hi = ch_gate[NCH-1:N_PHASE];
endmodule

// File: rtl/gg_guard_chk.sv
module gg_guard_chk #(
    parameter int FO_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] req_lo,
    input logic [2:0] req_hi,
    input logic       ls_uv_det,
    input logic [2:0] hs_uv_det,
    input logic [2:0] gate_lo,
    input logic [2:0] gate_hi,
    input logic       fault_n
);
    logic [15:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lo_run <= '0;
        else if (fault_n)        lo_run <= '0;
        else if (lo_run != '1)   lo_run <= lo_run + 1'b1;
    end

    a_r2_gate_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_lo & ~req_lo) | (gate_hi & ~req_hi)) == 3'b000);

    a_r3_ls_uv_kills_low: assert property (@(posedge clk) disable iff (!rst_n)
        ls_uv_det |-> (gate_lo == 3'b000));

    a_r4_ls_uv_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_uv_det) |=> !fault_n);

    a_r5_hs_uv_kills_own: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_uv_det & gate_hi) == 3'b000);

    a_r8_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> (lo_run >= 16'(FO_CYC)));

    a_r9_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_lo == 3'b000));

    a_r10_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_lo & ~$past(gate_lo) & ~(req_lo & ~$past(req_lo))) |
         (gate_hi & ~$past(gate_hi) & ~(req_hi & ~$past(req_hi)))) == 3'b000);
endmodule

bind gate_guard_top gg_guard_chk #(.FO_CYC(FO_CYC)) u_guard_chk (
    .clk(clk), .rst_n(rst_n), .req_lo(req_lo), .req_hi(req_hi),
    .ls_uv_det(ls_uv_det), .hs_uv_det(hs_uv_det),
    .gate_lo(gate_lo), .gate_hi(gate_hi), .fault_n(fault_n)
);

// File: tb/tb_gate_guard_top.sv
`timescale 1ns/1ps
module tb_gate_guard_top;
    localparam int FO  = 16;
    localparam int FLT = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic [2:0] req_lo, req_hi, hs_uv_det, hs_uv_clr;
    logic       ls_uv_det, ls_uv_clr, sc_flag;
    logic [2:0] gate_lo, gate_hi;
    logic       fault_n;

    gate_guard_top #(.FO_CYC(FO), .SC_FILT(FLT)) dut (
        .clk(clk), .rst_n(rst_n), .req_lo(req_lo), .req_hi(req_hi),
        .ls_uv_det(ls_uv_det), .ls_uv_clr(ls_uv_clr),
        .hs_uv_det(hs_uv_det), .hs_uv_clr(hs_uv_clr), .sc_flag(sc_flag),
        .gate_lo(gate_lo), .gate_hi(gate_hi), .fault_n(fault_n)
    );

    // staged stimulus, applied at the falling edge
    logic       s_rst_n = 1'b0;
    logic [2:0] s_lo = 3'b111, s_hi = 3'b111, s_hdet = 3'b000, s_hclr = 3'b000;
    logic       s_ldet = 1'b0, s_lclr = 1'b0, s_sc = 1'b0;
    string      tag = "R1";

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit m_ls_lock;
    bit m_hs_lock [3];
    int m_sc_run;
    bit m_sc_trip;
    int m_fo_left;
    bit m_need [6];
    bit m_last [6];

    task automatic model_reset();
        m_ls_lock = 0; m_sc_run = 0; m_sc_trip = 0; m_fo_left = 0;
        for (int i = 0; i < 3; i++) m_hs_lock[i] = 0;
        for (int i = 0; i < 6; i++) begin m_need[i] = 1; m_last[i] = 1; end
    endtask

    function automatic bit ch_req(int c);
        return (c < 3) ? s_lo[c] : s_hi[c-3];
    endfunction

    function automatic bit ch_blk(int c);
        if (c < 3) return m_ls_lock | s_ldet | m_sc_trip | (m_fo_left > 0);
        return m_hs_lock[c-3] | s_hdet[c-3];
    endfunction

    function automatic bit exp_gate(int c);
        bit r;
        if (!s_rst_n) return 0;
        r = ch_req(c) & ~m_last[c];
        return ch_req(c) & ~ch_blk(c) & (~m_need[c] | r);
    endfunction

    task automatic model_step();
        bit trig;
        bit nb [6];
        if (!s_rst_n) begin model_reset(); return; end
        for (int c = 0; c < 6; c++) begin
            bit r;
            r = ch_req(c) & ~m_last[c];
            nb[c] = ch_blk(c) | ~ch_req(c) | (m_need[c] & ~r);
        end
        trig = s_ldet | m_sc_trip;
        if (m_fo_left == 0)      m_fo_left = trig ? FO : 0;
        else if (m_fo_left == 1) m_fo_left = trig ? FO : 0;
        else                     m_fo_left = m_fo_left - 1;
        if (s_ldet) m_ls_lock = 1; else if (s_lclr) m_ls_lock = 0;
        for (int i = 0; i < 3; i++) begin
            if (s_hdet[i]) m_hs_lock[i] = 1; else if (s_hclr[i]) m_hs_lock[i] = 0;
        end
        if (s_sc) begin m_sc_run++; m_sc_trip = (m_sc_run >= FLT); end
        else begin m_sc_run = 0; m_sc_trip = 0; end
        for (int c = 0; c < 6; c++) begin m_need[c] = nb[c]; m_last[c] = ch_req(c); end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            logic [2:0] el, eh;
            logic       ef;
            @(negedge clk);
            rst_n = s_rst_n; req_lo = s_lo; req_hi = s_hi;
            ls_uv_det = s_ldet; ls_uv_clr = s_lclr;
            hs_uv_det = s_hdet; hs_uv_clr = s_hclr; sc_flag = s_sc;
            #1;
            for (int c = 0; c < 3; c++) begin
                el[c] = exp_gate(c);
                eh[c] = exp_gate(c + 3);
            end
            ef = !s_rst_n ? 1'b1 : (m_fo_left == 0);
            checks++;
            if (gate_lo !== el || gate_hi !== eh || fault_n !== ef) begin
                fails++;
                $display("FAIL %s t=%0t lo=%b/%b hi=%b/%b fault_n=%b/%b (actual/expected)",
                         tag, $time, gate_lo, el, gate_hi, eh, fault_n, ef);
            end
            @(posedge clk);
            model_step();
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 0; req_lo = 3'b111; req_hi = 3'b111; ls_uv_det = 0; ls_uv_clr = 0;
        hs_uv_det = 0; hs_uv_clr = 0; sc_flag = 0;

        // R1: reset with requests high, then release: still off until new edge
        tag = "R1"; tick(3);
        s_rst_n = 1; tick(4);
        s_lo = 3'b000; s_hi = 3'b000; tick(2);

        // R2: gates follow requests under several patterns
        tag = "R2";
        for (int i = 0; i < 8; i++) begin
            s_lo = 3'(i); s_hi = 3'(~i); tick(2);
        end
        s_lo = 3'b101; s_hi = 3'b011; tick(1);
        s_lo = 3'b111; s_hi = 3'b111; tick(3);

        // R3 and R4: low-side undervoltage, latched until clear; R10 rearm
        tag = "R3"; s_ldet = 1; tick(2);
        tag = "R4"; s_ldet = 0; tick(4);
        tag = "R3"; tick(FO);
        s_lclr = 1; tick(1); s_lclr = 0; tick(3);
        tag = "R10"; s_lo = 3'b000; tick(1); s_lo = 3'b111; tick(3);

        // R5: high-side undervoltage on phase V only
        tag = "R5"; s_hdet = 3'b010; tick(3);
        s_hdet = 3'b000; tick(2);
        s_hclr = 3'b010; tick(1); s_hclr = 3'b000; tick(2);
        tag = "R10"; s_hi = 3'b101; tick(1); s_hi = 3'b111; tick(2);
        tag = "R5"; s_hdet = 3'b001; s_hclr = 3'b100; tick(2);
        s_hdet = 3'b000; s_hclr = 3'b001; tick(1); s_hclr = 3'b000; tick(1);
        s_hi = 3'b000; tick(1); s_hi = 3'b111; tick(2);

        // R6: short bursts ignored, long burst trips; R7 high side untouched
        tag = "R6"; s_sc = 1; tick(FLT - 1); s_sc = 0; tick(3);
        s_sc = 1; tick(FLT - 1); s_sc = 0; s_lo = 3'b000; tick(1); s_lo = 3'b111; tick(2);
        tag = "R7"; s_sc = 1; tick(FLT + 3);
        s_sc = 0; tick(2);
        // R9: requests rising during the window stay off
        tag = "R9"; s_lo = 3'b000; tick(2); s_lo = 3'b110; tick(3);
        s_lo = 3'b000; tick(1); s_lo = 3'b011; tick(FO);
        tag = "R10"; tick(2); s_lo = 3'b000; tick(1); s_lo = 3'b111; tick(3);

        // R8: retrigger inside the pulse, and a condition outlasting the pulse
        tag = "R8"; s_ldet = 1; tick(1); s_ldet = 0; tick(5);
        s_ldet = 1; tick(1); s_ldet = 0; s_lclr = 1; tick(FO + 4);
        s_lclr = 0;
        s_sc = 1; tick(FLT + FO + 6); s_sc = 0; tick(FO + 4);
        s_lo = 3'b000; tick(1); s_lo = 3'b111; tick(3);
        tag = "R2"; s_lo = 3'b010; s_hi = 3'b100; tick(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule